// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block sits beside a UART's line, receive, transmit and modem logic and turns four raw condition flags into a single interrupt request plus an identification byte that software reads to learn which source needs attention. Each source is gated by its own bit in a 4-bit enable register. When several gated sources are active at once, only the most urgent one is reported.

The transmit-holding-empty source is level-based at its input but edge-based towards software. A pending flag is armed when the holding register becomes empty, or when its enable is switched on while the register is already empty. That flag is dropped by a write to the holding register. It is also dropped by a read of the identification byte that returned the holding-empty code. The other three sources follow their condition inputs directly. Their clearing happens upstream, when software reads the matching status or data register. Both outputs are registered, so a condition change appears on the next clock edge. A change of the holding-empty flag appears one edge later.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register is written with `en_wr`/`en_wdata` and read back on `ier_data`. Bit 0 enables receive ready, bit 1 holding empty, bit 2 line error and bit 3 modem change. Bits 7:4 always read 0. Reset clears the register to 0x00.
- R2: A source is active only while its condition and its enable bit are both 1. `irq` is the OR of the active sources, registered one edge after the inputs. With all enable bits 0, `irq` stays 0 whatever the conditions are.
- R3: `iir_data` bit 0 is 1 when no source is active and 0 otherwise. Bits 7:3 always read 0. After reset `iir_data` is 0x01.
- R4: `iir_data[2:0]` carries a priority code. Line error is highest with 110, then receive ready with 100, then holding empty with 010, then modem change with 000 (lowest).
- R5: The line error, receive ready and modem change sources follow their condition inputs. A source dropping its condition is removed from `irq`/`iir_data` on the next edge.
- R6: The holding-empty pending flag is set when `cond_thre` rises. It is also set when an enable write changes bit 1 from 0 to 1 while `cond_thre` is 1. The holding-empty code appears two edges after the rising input.
- R7: A `thr_wr` pulse clears the holding-empty pending flag. The output reflects this two edges later.
- R8: An `iir_rd` pulse clears the pending flag only when `iir_data[2:0]` reads 010 at that read. A read that returns a higher-priority code leaves the flag pending.
- R9: The pending flag is also cleared while `cond_thre` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| cond_line | input | 1 | Line status error condition |
| cond_rx | input | 1 | Receive data ready condition |
| cond_thre | input | 1 | Transmit holding register empty condition |
| cond_modem | input | 1 | Modem status change condition |
| irq | output | 1 | Interrupt request |
| iir_data | output | 8 | Identification byte |
| ier_data | output | 8 | Enable register readback |

## Verification
The assertions assume that strobes and conditions are synchronous to `clk` and stable across each edge. The priority properties also assume that `en_wr` does not fall in the same cycle as the condition being judged, because they compare the next output against the enable value currently read back. The bench changes every input just after a falling edge and holds strobes for exactly one cycle. This keeps every property antecedent aligned with the registered enable value that the datapath really used.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 4;
  // enable bit positions, fixed by the register layout software sees
  localparam int SRC_RX    = 0;
  localparam int SRC_TX    = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [2:0] {
    ID_NONE  = 3'b001,
    ID_LINE  = 3'b110,
    ID_RX    = 3'b100,
    ID_TX    = 3'b010,
    ID_MODEM = 3'b000
  } id_code_e;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
  import uirq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic          tx_arm
);
  // enabling the holding-empty source while already empty arms it
  assign tx_arm = wr & wdata[SRC_TX] & ~en_q[SRC_TX];

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata[NSRC-1:0];
  end
endmodule

// File: rtl/uirq_tx_pending.sv
module uirq_tx_pending (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic arm,
  input  logic thr_wr,
  input  logic id_rd_hit,
  output logic pend
);
  logic cond_d;
  logic set_ev;
  logic clr_ev;

  assign set_ev = (cond & ~cond_d) | (arm & cond);
  assign clr_ev = thr_wr | id_rd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_d <= 1'b0;
      pend   <= 1'b0;
    end else begin
      cond_d <= cond;
      pend   <= cond & (set_ev | (pend & ~clr_ev));
    end
  end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] active,
  output logic            any,
  output logic [2:0]      code
);
  assign any = |active;

  always_comb begin
    if (active[SRC_LINE])       code = ID_LINE;
    else if (active[SRC_RX])    code = ID_RX;
    else if (active[SRC_TX])    code = ID_TX;
    else if (active[SRC_MODEM]) code = ID_MODEM;
    else                        code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  input  logic          thr_wr,
  input  logic          iir_rd,
  input  logic          cond_line,
  input  logic          cond_rx,
  input  logic          cond_thre,
  input  logic          cond_modem,
  output logic          irq,
  output logic [DW-1:0] iir_data,
  output logic [DW-1:0] ier_data
);
  localparam int PADW = DW - NSRC;
  localparam int IDPAD = DW - 3;

  logic [NSRC-1:0] en_q;
  logic            tx_arm;
  logic            tx_pend;
  logic            id_rd_hit;
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] active;
  logic            any;
  logic [2:0]      code;
  logic            irq_q;
  logic [2:0]      code_q;

  uirq_enable_reg #(.DW(DW)) u_en (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .tx_arm(tx_arm)
  );

  assign id_rd_hit = iir_rd & (code_q == ID_TX);

  uirq_tx_pending u_tx (
    .clk(clk), .rst(rst), .cond(cond_thre), .arm(tx_arm),
    .thr_wr(thr_wr), .id_rd_hit(id_rd_hit), .pend(tx_pend)
  );

  always_comb begin
    raw            = '0;
    raw[SRC_RX]    = cond_rx;
    raw[SRC_TX]    = tx_pend;
    raw[SRC_LINE]  = cond_line;
    raw[SRC_MODEM] = cond_modem;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign active[i] = raw[i] & en_q[i];
  end

  uirq_prio_enc u_enc (.active(active), .any(any), .code(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      code_q <= ID_NONE;
    end else begin
      irq_q  <= any;
      code_q <= code;
    end
  end

  assign irq      = irq_q;
  assign iir_data = {{IDPAD{1'b0}}, code_q};
  assign ier_data = {{PADW{1'b0}}, en_q};
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cond_line,
  input logic          cond_rx,
  input logic          irq,
  input logic [DW-1:0] iir_data,
  input logic [DW-1:0] ier_data
);
  a_r1_ier_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ier_data[DW-1:4] == '0);

  a_r3_id_upper_zero: assert property (@(posedge clk) disable iff (rst)
    iir_data[DW-1:3] == '0);

  a_r3_none_means_quiet: assert property (@(posedge clk) disable iff (rst)
    iir_data[0] |-> (!irq && iir_data[2:1] == 2'b00));

  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (ier_data[3:0] == 4'h0) |=> !irq);

  a_r4_line_top: assert property (@(posedge clk) disable iff (rst)
    (cond_line && ier_data[2]) |=> (iir_data[2:0] == 3'b110 && irq));

  a_r4_rx_second: assert property (@(posedge clk) disable iff (rst)
    (cond_rx && ier_data[0] && !(cond_line && ier_data[2]))
      |=> (iir_data[2:0] == 3'b100));
endmodule

bind uart_irq_ident uirq_ident_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cond_line(cond_line), .cond_rx(cond_rx),
  .irq(irq), .iir_data(iir_data), .ier_data(ier_data)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       thr_wr = 1'b0;
  logic       iir_rd = 1'b0;
  logic       cond_line = 1'b0;
  logic       cond_rx = 1'b0;
  logic       cond_thre = 1'b0;
  logic       cond_modem = 1'b0;
  logic       irq;
  logic [7:0] iir_data;
  logic [7:0] ier_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .cond_line(cond_line),
    .cond_rx(cond_rx), .cond_thre(cond_thre), .cond_modem(cond_modem),
    .irq(irq), .iir_data(iir_data), .ier_data(ier_data)
  );

  // {enable[3:0], line, rx, modem, exp_irq, exp_code[2:0]}, holding-empty idle
  localparam logic [10:0] VEC [10] = '{
    {4'hF, 3'b111, 1'b1, 3'b110},
    {4'hF, 3'b011, 1'b1, 3'b100},
    {4'hF, 3'b001, 1'b1, 3'b000},
    {4'hF, 3'b000, 1'b0, 3'b001},
    {4'h0, 3'b111, 1'b0, 3'b001},
    {4'hB, 3'b101, 1'b1, 3'b000},
    {4'h4, 3'b111, 1'b1, 3'b110},
    {4'h1, 3'b110, 1'b1, 3'b100},
    {4'h8, 3'b111, 1'b1, 3'b000},
    {4'h8, 3'b000, 1'b0, 3'b001}
  };

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got irq/byte %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v;
    step(1);
    en_wr = 1'b0;
  endtask

  task automatic pulse_thr();
    thr_wr = 1'b1; step(1); thr_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    iir_rd = 1'b1; step(1); iir_rd = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset id", {irq, iir_data}, {1'b0, 8'h01});
    check("R1 reset enable", {1'b0, ier_data}, 9'h000);

    write_en(8'hFF);
    check("R1 upper enable bits read zero", {1'b0, ier_data}, 9'h00F);

    for (int i = 0; i < 10; i++) begin
      en_wr = 1'b1; en_wdata = {4'h0, VEC[i][10:7]};
      {cond_line, cond_rx, cond_modem} = VEC[i][6:4];
      step(1);
      en_wr = 1'b0;
      step(1);
      check($sformatf("R2 R4 vector %0d", i), {irq, iir_data},
            {VEC[i][3], 5'b0, VEC[i][2:0]});
    end
    {cond_line, cond_rx, cond_modem} = 3'b000;

    // R5: line error follows its condition
    write_en(8'h04);
    cond_line = 1'b1; step(1);
    check("R5 line set", {irq, iir_data}, {1'b1, 8'h06});
    cond_line = 1'b0; step(1);
    check("R5 line cleared by condition", {irq, iir_data}, {1'b0, 8'h01});

    // R6: rising empty condition, two-edge latency
    write_en(8'h02);
    cond_thre = 1'b1; step(1);
    check("R6 one edge after rise", {irq, iir_data}, {1'b0, 8'h01});
    step(1);
    check("R6 holding empty reported", {irq, iir_data}, {1'b1, 8'h02});

    // R8: ID read returning 010 clears it
    pulse_rd();
    step(1);
    check("R8 read of 010 clears", {irq, iir_data}, {1'b0, 8'h01});

    // R6: re-arm by enabling while empty
    write_en(8'h00);
    write_en(8'h02);
    step(1);
    check("R6 enable 0->1 while empty arms", {irq, iir_data}, {1'b1, 8'h02});

    // R7: holding write clears
    pulse_thr();
    step(1);
    check("R7 holding write clears", {irq, iir_data}, {1'b0, 8'h01});

    // R8: read while higher code shown keeps pending
    cond_thre = 1'b0;
    write_en(8'h06);
    cond_thre = 1'b1; cond_line = 1'b1;
    step(2);
    check("R4 line over holding empty", {irq, iir_data}, {1'b1, 8'h06});
    pulse_rd();
    step(1);
    check("R8 read of 110 keeps pending", {irq, iir_data}, {1'b1, 8'h06});
    cond_line = 1'b0; step(1);
    check("R8 holding empty still pending", {irq, iir_data}, {1'b1, 8'h02});

    // R9: condition falling drops pending
    cond_thre = 1'b0; step(2);
    check("R9 condition low clears", {irq, iir_data}, {1'b0, 8'h01});
    cond_thre = 1'b1; step(2);
    check("R9 re-rise sets again", {irq, iir_data}, {1'b1, 8'h02});

    // R2: polled mode masks everything
    cond_line = 1'b1; cond_rx = 1'b1; cond_modem = 1'b1;
    write_en(8'h00);
    step(1);
    check("R2 all masked", {irq, iir_data}, {1'b0, 8'h01});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule